// File: doc/BRIEF.md
# Dual-Rail Tree Magnitude Comparator

This block compares two unsigned operands, A and B, whose bits arrive on two rails each. It reports the ordering of the operands as a three-line one-hot code: less, greater or equal. Every bit position has a cell that turns its four rails into a local less/greater/equal triple. A tree of combining nodes, whose depth grows with the logarithm of the width, merges these triples, and the higher-order half of each pair takes precedence. A result is therefore only held back by the most significant position that differs. Equal operands are the slowest case, since every position must agree.

The block is a clocked model of a return-to-spacer handshake. The producer raises a complete data word on the rails. The block registers the root result and raises `done`. The producer then drops every rail to zero, and the block clears `done` and the result lines. An input bit with both rails high is an illegal code. It raises `err` and can never lead to a reported result.

Top module: `dr_tree_comparator`

## Requirements
- R1: For each bit i, `aT[i]=1,aF[i]=0` encodes 1 and `aT[i]=0,aF[i]=1` encodes 0. Both rails low is the spacer state and both rails high is illegal. The same rules apply to `bT`/`bF`.
- R2: While `done` is high, exactly one of `resS`, `resG`, `resE` is high. `resS` means A<B, `resG` means A>B and `resE` means A=B, all as unsigned numbers. At all other times, at most one of the three is high.
- R3: With `done` low, suppose that at a rising clock edge every bit of both operands holds a valid code. Then `done` and the result lines are set after that edge.
- R4: While any input bit is still in the spacer state, `done` stays low and all three result lines stay low. This holds even when the leading bits already decide the outcome.
- R5: `err` is high after any clock edge at which some input bit carries the illegal code, and low after an edge at which none does. `done` never rises while an illegal code is present.
- R6: Once `done` is high, the block ignores new valid operands applied without an intervening all-spacer word. `done` and the result lines keep their values.
- R7: With `done` high, an edge at which every rail of both operands is low clears `done` and all three result lines after that edge.
- R8: While `rstN` is low, `done`, `err`, `resS`, `resG` and `resE` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aT | input | W | True rails of operand A |
| aF | input | W | False rails of operand A |
| bT | input | W | True rails of operand B |
| bF | input | W | False rails of operand B |
| resS | output | 1 | A is smaller than B |
| resG | output | 1 | A is greater than B |
| resE | output | 1 | A equals B |
| done | output | 1 | Result valid (completion) |
| err | output | 1 | An illegal rail pair was seen at the last edge |

## Verification
The assertions assume that the producer keeps to the four-phase discipline: a word goes from spacer to complete data and back to spacer. They also assume that the root of the tree is one-hot whenever every bit is valid. The stimulus changes rails only on the falling clock edge. Between data words it drives an all-spacer word, except in the deliberate no-spacer and illegal-code cases. Those cases are used to probe the hold rule and the error flag. Equal pairs are forced often so that the full-depth case is exercised, and partial words check that an early decision does not raise `done`.

// File: rtl/dr_cmp_pkg.sv
package dr_cmp_pkg;

  typedef struct packed {
    logic s;
    logic g;
    logic e;
  } cmpTri_t;

  typedef struct packed {
    logic load;
    logic clear;
  } cmpStrobe_t;

  localparam cmpTri_t TRI_EQ   = '{s: 1'b0, g: 1'b0, e: 1'b1};
  localparam cmpTri_t TRI_NONE = '{s: 1'b0, g: 1'b0, e: 1'b0};

  // high-order group wins unless it is equal
  function automatic cmpTri_t mergeTri(input cmpTri_t hi, input cmpTri_t lo);
    cmpTri_t r;
    r.s = hi.s | (hi.e & lo.s);
    r.g = hi.g | (hi.e & lo.g);
    r.e = hi.e & lo.e;
    return r;
  endfunction

endpackage

// File: rtl/dr_bit_cell.sv
module dr_bit_cell
  import dr_cmp_pkg::*;
(
  input  logic    aT,
  input  logic    aF,
  input  logic    bT,
  input  logic    bF,
  output cmpTri_t cellTri,
  output logic    cellValid,
  output logic    cellSpacer,
  output logic    cellIllegal
);
  logic aValid;
  logic bValid;

  assign aValid      = aT ^ aF;
  assign bValid      = bT ^ bF;
  assign cellValid   = aValid & bValid;
  assign cellIllegal = (aT & aF) | (bT & bF);
  assign cellSpacer  = ~(aT | aF | bT | bF);

  assign cellTri.g = cellValid & aT & bF;
  assign cellTri.s = cellValid & aF & bT;
  assign cellTri.e = cellValid & ~(aT ^ bT);
endmodule

// File: rtl/dr_cmp_datapath.sv
module dr_cmp_datapath
  import dr_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [W-1:0] aT,
  input  logic [W-1:0] aF,
  input  logic [W-1:0] bT,
  input  logic [W-1:0] bF,
  input  cmpStrobe_t strobe,
  output logic       allValid,
  output logic       allSpacer,
  output logic       anyIllegal,
  output logic       rootOneHot,
  output cmpTri_t    result
);
  localparam int LEVELS = (W > 1) ? $clog2(W) : 1;
  localparam int NPAD   = 1 << LEVELS;

  cmpTri_t leafTri [NPAD];
  logic [W-1:0] bitValid;
  logic [W-1:0] bitSpacer;
  logic [W-1:0] bitIllegal;

  for (genvar i = 0; i < NPAD; i++) begin : g_leaf
    if (i < W) begin : g_cell
      dr_bit_cell u_cell (
        .aT(aT[i]), .aF(aF[i]), .bT(bT[i]), .bF(bF[i]),
        .cellTri(leafTri[i]),
        .cellValid(bitValid[i]),
        .cellSpacer(bitSpacer[i]),
        .cellIllegal(bitIllegal[i])
      );
    end else begin : g_pad
      assign leafTri[i] = TRI_EQ;
    end
  end

  cmpTri_t node [LEVELS+1][NPAD];
  cmpTri_t rootTri;

  always_comb begin
    for (int l = 0; l <= LEVELS; l++) begin
      for (int i = 0; i < NPAD; i++) begin
        node[l][i] = TRI_NONE;
      end
    end
    for (int i = 0; i < NPAD; i++) begin
      node[0][i] = leafTri[i];
    end
    for (int l = 1; l <= LEVELS; l++) begin
      for (int i = 0; i < (NPAD >> l); i++) begin
        node[l][i] = mergeTri(node[l-1][2*i+1], node[l-1][2*i]);
      end
    end
    rootTri = node[LEVELS][0];
  end

  assign allValid   = &bitValid;
  assign allSpacer  = &bitSpacer;
  assign anyIllegal = |bitIllegal;
  assign rootOneHot = $onehot({rootTri.s, rootTri.g, rootTri.e});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= TRI_NONE;
    end else if (strobe.clear) begin
      result <= TRI_NONE;
    end else if (strobe.load) begin
      result <= rootTri;
    end
  end

  // R2: a fully valid word always resolves to one outcome at the root
  a_r2_root_resolves: assert property (@(posedge clk) disable iff (!rstN)
    allValid |-> rootOneHot);

  // R2: registered result never shows two outcomes
  a_r2_result_onehot0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({result.s, result.g, result.e}));
endmodule

// File: rtl/dr_cmp_control.sv
module dr_cmp_control
  import dr_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       allValid,
  input  logic       allSpacer,
  input  logic       anyIllegal,
  input  logic       rootOneHot,
  output cmpStrobe_t strobe,
  output logic       done,
  output logic       err
);
  typedef enum logic {PH_EMPTY, PH_FULL} phase_t;
  phase_t phase;

  assign strobe.load  = (phase == PH_EMPTY) && allValid && !anyIllegal && rootOneHot;
  assign strobe.clear = (phase == PH_FULL) && allSpacer;
  assign done         = (phase == PH_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_EMPTY;
      err   <= 1'b0;
    end else begin
      err <= anyIllegal;
      if (strobe.load)       phase <= PH_FULL;
      else if (strobe.clear) phase <= PH_EMPTY;
    end
  end

  // R3/R4: completion only after a fully valid word
  a_r3_rise_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(allValid));

  // R7: completion only drops after an all-spacer word
  a_r7_fall_needs_spacer: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(allSpacer));
endmodule

// File: rtl/dr_tree_comparator.sv
module dr_tree_comparator
  import dr_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] aT,
  input  logic [W-1:0] aF,
  input  logic [W-1:0] bT,
  input  logic [W-1:0] bF,
  output logic         resS,
  output logic         resG,
  output logic         resE,
  output logic         done,
  output logic         err
);
  cmpStrobe_t strobe;
  cmpTri_t    result;
  logic       allValid;
  logic       allSpacer;
  logic       anyIllegal;
  logic       rootOneHot;

  dr_cmp_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN),
    .aT(aT), .aF(aF), .bT(bT), .bF(bF),
    .strobe(strobe),
    .allValid(allValid), .allSpacer(allSpacer),
    .anyIllegal(anyIllegal), .rootOneHot(rootOneHot),
    .result(result)
  );

  dr_cmp_control u_ctl (
    .clk(clk), .rstN(rstN),
    .allValid(allValid), .allSpacer(allSpacer),
    .anyIllegal(anyIllegal), .rootOneHot(rootOneHot),
    .strobe(strobe), .done(done), .err(err)
  );

  assign resS = result.s;
  assign resG = result.g;
  assign resE = result.e;

  // R2: a raised done always carries exactly one outcome
  a_r2_done_onehot: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({resS, resG, resE}));

  // R6: outcome is frozen while done stays high
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> $stable({resS, resG, resE}));

  // R5: a new completion never coincides with an illegal code
  a_r5_no_done_with_err: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !err);
endmodule

// File: tb/sim_dr_tree_comparator.sv
module sim_dr_tree_comparator;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [2*W-1:0] VECS [NVEC] = '{
    16'h0000, 16'hFFFF, 16'h8000, 16'h0080, 16'h0001,
    16'h0100, 16'h7F80, 16'hA5A5, 16'hA5A4, 16'h5AA5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aT = '0, aF = '0, bT = '0, bF = '0;
  logic resS, resG, resE, done, err;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  dr_tree_comparator #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .aT(aT), .aF(aF), .bT(bT), .bF(bF),
    .resS(resS), .resG(resG), .resE(resE), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {resS, resG, resE, done, err};
  endfunction

  function automatic logic [4:0] expect_cmp(input logic [W-1:0] a, input logic [W-1:0] b);
    return {a < b, a > b, a == b, 1'b1, 1'b0};
  endfunction

  task automatic drive_data(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    aT = a; aF = ~a; bT = b; bF = ~b;
  endtask

  task automatic drive_spacer();
    @(negedge clk);
    aT = '0; aF = '0; bT = '0; bF = '0;
  endtask

  task automatic run_pair(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    drive_data(a, b);
    @(negedge clk);
    chk(req, outs(), expect_cmp(a, b));
    aT = '0; aF = '0; bT = '0; bF = '0;
    @(negedge clk);
    chk("R7 spacer clears", outs(), 5'b00000);
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 reset", outs(), 5'b00000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 after release", outs(), 5'b00000);

    // R1/R2/R3: table vectors
    for (int i = 0; i < NVEC; i++) begin
      run_pair("R2 table", VECS[i][2*W-1:W], VECS[i][W-1:0]);
    end

    // R2/R3: random pairs, forced equal every third
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (i % 3 == 0) ? ra : W'($urandom);
      run_pair("R3 random", ra, rb);
    end

    // R4: leading bit decides but low bits of B still spacer
    drive_spacer();
    @(negedge clk);
    aT = 8'h80; aF = 8'h7F; bT = 8'h00; bF = 8'hF0;
    @(negedge clk);
    chk("R4 partial word", outs(), 5'b00000);
    bF = 8'hFF;
    @(negedge clk);
    chk("R3 completes", outs(), 5'b01010);

    // R6: new data without spacer is ignored
    aT = 8'h01; aF = 8'hFE; bT = 8'h02; bF = 8'hFD;
    @(negedge clk);
    chk("R6 no spacer hold", outs(), 5'b01010);
    @(negedge clk);
    chk("R6 still held", outs(), 5'b01010);

    // R7: one rail still up keeps done
    aT = '0; aF = '0; bT = '0; bF = 8'h01;
    @(negedge clk);
    chk("R7 not all spacer", outs(), 5'b01010);
    bF = '0;
    @(negedge clk);
    chk("R7 cleared", outs(), 5'b00000);

    // R5: illegal code in bit 3 of A, other bits valid
    aT = 8'h0F; aF = 8'hF8; bT = 8'h00; bF = 8'hFF;
    @(negedge clk);
    chk("R5 illegal flag", outs(), 5'b00001);
    @(negedge clk);
    chk("R5 illegal persists", outs(), 5'b00001);
    aT = '0; aF = '0; bT = '0; bF = '0;
    @(negedge clk);
    chk("R5 err clears", outs(), 5'b00000);

    // R5: illegal on B rails, both operands otherwise equal
    aT = 8'h33; aF = 8'hCC; bT = 8'h33; bF = 8'hCD;
    @(negedge clk);
    chk("R5 illegal on B", outs(), 5'b00001);
    drive_spacer();
    @(negedge clk);
    chk("R5 recovered", outs(), 5'b00000);

    // R8: reset while done is high
    drive_data(8'h10, 8'h20);
    @(negedge clk);
    chk("R2 before reset", outs(), 5'b10010);
    rstN = 1'b0;
    #1;
    chk("R8 async reset", outs(), 5'b00000);
    drive_spacer();
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", outs(), 5'b00000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule